// File: doc/BRIEF.md
# External Memory Bus Master Controller

This block sits between an internal requester and an external parallel memory bus. It turns each accepted request into one external bus cycle. The request holds a 26-bit address, a direction flag, a conditional-execution pair, a short-word flag and 32 bits of write data. The top two address bits choose one of four active-low bank selects, and the low 24 bits go out on the address pins. The block drives the read strobe or the write strobe. For writes it also drives an early synchronous-write indicator. The cycle is stretched while the acknowledge input is low. At the end the requester gets a one-cycle done pulse, with read data or an abort flag.

Conditional accesses still present the address, the bank select and the early write indicator. When a write's condition is false, the write strobe is withheld and the cycle closes as an aborted write. A suspend input releases the bus from the following cycle. The drive-enable `bus_oe` goes low, and any access in flight is parked. When suspend drops, the parked access restarts from its address phase.

The controller is a state machine with these states:
- IDLE: ready for a request. Accepting a request moves it to ADDR.
- ADDR: address, select and early write indicator are driven, and both strobes stay high. It moves to STROBE, or to SUSPENDED.
- STROBE: first strobe cycle. Acknowledge high moves it to DONE. Acknowledge low moves it to WAIT_ACK. An aborted write moves to DONE at once. Suspend moves it to SUSPENDED.
- WAIT_ACK: strobe held. Acknowledge high moves it to DONE. Suspend moves it to SUSPENDED.
- DONE: done pulse, bus inactive. It returns to IDLE.
- SUSPENDED: bus parked and floated. It moves to ADDR once suspend is low.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While the state is ADDR, STROBE or WAIT_ACK, `bus_ms_n` equals the inverse of (1 << addr[25:24]), so bank 0 maps to bit 0, and `bus_addr` equals addr[23:0]. In every other state `bus_ms_n` is 4'hF.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only in IDLE. With acknowledge already high, `rsp_done` is high in the third cycle after the accepting edge.
- R3: `bus_sw_n` is low from ADDR until the cycle ends for every write, including a conditional write whose condition is false. It stays high for reads.
- R4: A write with `req_cond`=1 and `req_cond_met`=0 never drives `bus_wr_n` low. It finishes after STROBE without waiting for acknowledge, and `rsp_abort` is high with `rsp_done`. Every other write drives `bus_wr_n` low in STROBE and WAIT_ACK.
- R5: A conditional access drives its bank select whether or not its condition is met. A conditional read completes as a normal read.
- R6: Each cycle in which `bus_ack` is sampled low in STROBE or WAIT_ACK adds one wait state with the strobe held low. Done comes 3+N cycles after acceptance for N low samples.
- R7: `bus_rd_n` and `bus_wr_n` are never low together. `bus_doe` is high only for writes in ADDR, STROBE and WAIT_ACK, and it is low while the bus is floated.
- R8: A 32-bit write drives `bus_dout` = wdata. A short write drives {16'h0, wdata[15:0]}. A short read returns {16'h0, din[15:0]}.
- R9: Read data is captured on the edge in STROBE or WAIT_ACK where acknowledge is high. It is presented on `rsp_rdata` with a `rsp_done` pulse that lasts exactly one cycle.
- R10: `bus_oe` is low in the cycle after `bus_susp` is sampled high. An access in flight then parks in SUSPENDED with its selects and strobes inactive and no done. After release it re-runs from ADDR and completes with correct data.
- R11: After reset the state is IDLE: `req_ready`=1, `rsp_done`=0, all selects and strobes high, `bus_oe`=1, `bus_doe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this edge |
| req_addr | input | 26 | Request address; bits 25:24 pick the bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cond | input | 1 | Access is conditional |
| req_cond_met | input | 1 | Condition outcome of a conditional access |
| req_short | input | 1 | 16-bit short-word transfer |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_abort | output | 1 | Completion was an aborted write |
| rsp_rdata | output | 32 | Read data, valid with done |
| bus_addr | output | 24 | External address |
| bus_dout | output | 32 | External write data |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 32 | External read data |
| bus_ms_n | output | 4 | Active-low bank selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_sw_n | output | 1 | Active-low early write indicator |
| bus_oe | output | 1 | Drive enable for address, selects and strobes; low = high impedance |
| bus_ack | input | 1 | Acknowledge; low adds wait states |
| bus_susp | input | 1 | Suspend; float the bus and park the access |

## Verification
The bench sends accesses to all four banks with zero to three wait states. It mixes reads and writes, long and short words, and met and failed conditions. A wrong bank decode would show a bad select, and a missing wait state would finish a cycle early and capture stale read data. A failed conditional write is checked for a write strobe that must never appear, a set abort flag and a still-asserted early write indicator. Suspend is applied both in the middle of a waited read and before a request arrives. A design that kept driving the bus, issued done while parked, or failed to restart the cycle would show a wrong drive-enable, an early done or wrong read data.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STROBE,
        ST_WAIT_ACK,
        ST_DONE,
        ST_SUSP
    } ebc_state_e;
endpackage

// File: rtl/ebc_bank_decode.sv
module ebc_bank_decode #(
    parameter int SEL_W = 2,
    localparam int BANKS = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [BANKS-1:0] sel_n
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign sel_n[b] = !(en && (sel == SEL_W'(b)));
    end
endmodule

// File: rtl/ebc_fsm.sv
module ebc_fsm
    import ebc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic is_write,
    input  logic is_abort,
    input  logic bus_ack,
    input  logic bus_susp,
    output logic req_ready,
    output logic load,
    output logic addr_phase,
    output logic strobe_phase,
    output logic capture_rd,
    output logic done,
    output logic bus_oe
);
    ebc_state_e state, state_nx;
    logic       float_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            float_q <= 1'b0;
        end else begin
            state   <= state_nx;
            float_q <= bus_susp;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_nx = ST_ADDR;
            ST_ADDR:     state_nx = bus_susp ? ST_SUSP : ST_STROBE;
            ST_STROBE: begin
                if (bus_susp)      state_nx = ST_SUSP;
                else if (is_abort) state_nx = ST_DONE;
                else if (bus_ack)  state_nx = ST_DONE;
                else               state_nx = ST_WAIT_ACK;
            end
            ST_WAIT_ACK: begin
                if (bus_susp)     state_nx = ST_SUSP;
                else if (bus_ack) state_nx = ST_DONE;
            end
            ST_DONE:     state_nx = ST_IDLE;
            ST_SUSP:     if (!bus_susp) state_nx = ST_ADDR;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        addr_phase   = 1'b0;
        strobe_phase = 1'b0;
        done         = 1'b0;
        unique case (state)
            ST_IDLE:     req_ready = 1'b1;
            ST_ADDR:     addr_phase = 1'b1;
            ST_STROBE,
            ST_WAIT_ACK: begin
                addr_phase   = 1'b1;
                strobe_phase = 1'b1;
            end
            ST_DONE:     done = 1'b1;
            ST_SUSP:     ;
            default:     ;
        endcase
        load       = req_ready && req_valid;
        capture_rd = strobe_phase && bus_ack && !bus_susp && !is_write;
        bus_oe     = !float_q;
    end

    p_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_susp |=> !bus_oe);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_phase && !bus_ack && !bus_susp && !is_abort) |=> strobe_phase);
    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!req_ready && addr_phase));
endmodule

// File: rtl/ebc_datapath.sv
module ebc_datapath #(
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 32,
    parameter int SHORT_W = 16,
    parameter int SEL_W   = 2,
    localparam int LOW_W  = ADDR_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_cond,
    input  logic              req_cond_met,
    input  logic              req_short,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_din,
    output logic [LOW_W-1:0]  low_addr,
    output logic [SEL_W-1:0]  bank_sel,
    output logic              is_write,
    output logic              is_abort,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] addr_q;
    logic              short_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            is_write <= 1'b0;
            is_abort <= 1'b0;
            short_q  <= 1'b0;
            wdata_q  <= '0;
            rd_data  <= '0;
        end else begin
            if (load) begin
                addr_q   <= req_addr;
                is_write <= req_write;
                is_abort <= req_write && req_cond && !req_cond_met;
                short_q  <= req_short;
                wdata_q  <= req_wdata;
            end
            if (capture_rd) begin
                rd_data <= short_q ? DATA_W'(bus_din[SHORT_W-1:0]) : bus_din;
            end
        end
    end

    assign low_addr = addr_q[LOW_W-1:0];
    assign bank_sel = addr_q[ADDR_W-1:LOW_W];
    assign wr_data  = short_q ? DATA_W'(wdata_q[SHORT_W-1:0]) : wdata_q;
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 32,
    parameter int SHORT_W = 16,
    parameter int SEL_W   = 2,
    localparam int LOW_W  = ADDR_W - SEL_W,
    localparam int BANKS  = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_cond,
    input  logic              req_cond_met,
    input  logic              req_short,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_abort,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [LOW_W-1:0]  bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    output logic [BANKS-1:0]  bus_ms_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_sw_n,
    output logic              bus_oe,
    input  logic              bus_ack,
    input  logic              bus_susp
);
    logic             load, addr_phase, strobe_phase, capture_rd, done;
    logic             is_write, is_abort;
    logic [SEL_W-1:0] bank_sel;

    ebc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .is_write     (is_write),
        .is_abort     (is_abort),
        .bus_ack      (bus_ack),
        .bus_susp     (bus_susp),
        .req_ready    (req_ready),
        .load         (load),
        .addr_phase   (addr_phase),
        .strobe_phase (strobe_phase),
        .capture_rd   (capture_rd),
        .done         (done),
        .bus_oe       (bus_oe)
    );

    ebc_datapath #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SHORT_W (SHORT_W),
        .SEL_W   (SEL_W)
    ) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .capture_rd   (capture_rd),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_cond     (req_cond),
        .req_cond_met (req_cond_met),
        .req_short    (req_short),
        .req_wdata    (req_wdata),
        .bus_din      (bus_din),
        .low_addr     (bus_addr),
        .bank_sel     (bank_sel),
        .is_write     (is_write),
        .is_abort     (is_abort),
        .wr_data      (bus_dout),
        .rd_data      (rsp_rdata)
    );

    ebc_bank_decode #(.SEL_W(SEL_W)) u_dec (
        .en    (addr_phase),
        .sel   (bank_sel),
        .sel_n (bus_ms_n)
    );

    assign bus_rd_n  = !(strobe_phase && !is_write);
    assign bus_wr_n  = !(strobe_phase && is_write && !is_abort);
    assign bus_sw_n  = !(addr_phase && is_write);
    assign bus_doe   = addr_phase && is_write && bus_oe;
    assign rsp_done  = done;
    assign rsp_abort = done && is_abort;

    p_ms_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_ms_n));
    p_ms_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready || rsp_done) |-> (bus_ms_n == '1));
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));
    p_doe_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_doe);
endmodule

// File: tb/sim_ext_bus_ctrl.sv
module sim_ext_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [25:0] req_addr = '0;
    logic        req_write = 1'b0, req_cond = 1'b0, req_cond_met = 1'b0, req_short = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done, rsp_abort;
    logic [31:0] rsp_rdata;
    logic [23:0] bus_addr;
    logic [31:0] bus_dout, bus_din;
    logic        bus_doe;
    logic [3:0]  bus_ms_n;
    logic        bus_rd_n, bus_wr_n, bus_sw_n, bus_oe;
    logic        bus_ack = 1'b1;
    logic        bus_susp = 1'b0;

    always #5 clk = ~clk;

    ext_bus_ctrl u0 (.*);

    assign bus_din = {8'h5A, bus_addr} ^ 32'h3C3C_0F0F;

    typedef struct {
        logic [25:0] addr;
        logic        wr;
        logic        abort;
        logic [31:0] data;
    } exp_t;
    exp_t sb[$];

    int checks = 0, fails = 0;
    int waits = 0;
    int scnt = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // acknowledge responder
    always @(negedge clk) begin
        if (!bus_rd_n || !bus_wr_n) begin
            bus_ack = (scnt >= waits);
            scnt++;
        end else begin
            scnt = 0;
            bus_ack = (waits == 0);
        end
    end

    // monitor
    bit saw_rd = 0, saw_wr = 0, saw_sw = 0, both = 0, doe_rd = 0;
    logic [3:0]  ms_seen = 4'hF;
    logic [23:0] addr_seen = '0;
    logic [31:0] dout_seen = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_rd_n) saw_rd = 1;
            if (!bus_wr_n) begin saw_wr = 1; dout_seen = bus_dout; end
            if (!bus_sw_n) saw_sw = 1;
            if (!bus_rd_n && !bus_wr_n) both = 1;
            if (!bus_rd_n && bus_doe) doe_rd = 1;
            if (bus_ms_n != 4'hF) begin ms_seen = bus_ms_n; addr_seen = bus_addr; end
            if (rsp_done) begin
                exp_t e;
                if (sb.size() == 0) begin
                    chk(0, "R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    e = sb.pop_front();
                    chk(ms_seen == ~(4'b1 << e.addr[25:24]), "R1/R5 bank select", {28'd0, ms_seen}, {28'd0, ~(4'b1 << e.addr[25:24])});
                    chk(addr_seen == e.addr[23:0], "R1 address", {8'd0, addr_seen}, {8'd0, e.addr[23:0]});
                    chk(saw_sw == e.wr, "R3 early write indicator", {31'd0, saw_sw}, {31'd0, e.wr});
                    chk(saw_wr == (e.wr && !e.abort), "R4 write strobe", {31'd0, saw_wr}, {31'd0, e.wr && !e.abort});
                    chk(saw_rd == !e.wr, "R2 read strobe", {31'd0, saw_rd}, {31'd0, !e.wr});
                    chk(rsp_abort == e.abort, "R4 abort flag", {31'd0, rsp_abort}, {31'd0, e.abort});
                    chk(!both && !doe_rd, "R7 strobe exclusion and doe", {30'd0, both, doe_rd}, 32'd0);
                    if (!e.wr)
                        chk(rsp_rdata == e.data, "R8/R9 read data", rsp_rdata, e.data);
                    else if (!e.abort)
                        chk(dout_seen == e.data, "R8 write data", dout_seen, e.data);
                end
                saw_rd = 0; saw_wr = 0; saw_sw = 0; both = 0; doe_rd = 0; ms_seen = 4'hF;
            end
        end
    end

    function automatic logic [31:0] rd_model(input logic [25:0] a, input bit s);
        logic [31:0] v;
        v = {8'h5A, a[23:0]} ^ 32'h3C3C_0F0F;
        return s ? {16'h0, v[15:0]} : v;
    endfunction

    task automatic do_txn(input logic [25:0] a, input bit w, input bit c, input bit m,
                          input bit s, input logic [31:0] wd, input int wt, input bit chk_lat);
        exp_t e;
        int lat;
        e.addr  = a;
        e.wr    = w;
        e.abort = w && c && !m;
        e.data  = w ? (s ? {16'h0, wd[15:0]} : wd) : rd_model(a, s);
        sb.push_back(e);
        waits = wt;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_addr = a; req_write = w; req_cond = c;
        req_cond_met = m; req_short = s; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 0;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (rsp_done) break;
        end
        if (chk_lat) begin
            int exp_lat;
            exp_lat = e.abort ? 3 : 3 + wt;
            chk(lat == exp_lat, e.abort ? "R4 abort latency" : "R2/R6 latency", lat, exp_lat);
        end
        @(negedge clk);
        chk(!rsp_done, "R9 done one cycle", {31'd0, rsp_done}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready == 1 && rsp_done == 0, "R11 ready/done", {30'd0, req_ready, rsp_done}, 32'd2);
        chk(bus_ms_n == 4'hF && bus_rd_n && bus_wr_n && bus_sw_n, "R11 bus idle",
            {24'd0, bus_ms_n, bus_rd_n, bus_wr_n, bus_sw_n, 1'b0}, 32'hFE);
        chk(bus_oe == 1 && bus_doe == 0, "R11 enables", {30'd0, bus_oe, bus_doe}, 32'd2);
        rst_n = 1;
        @(negedge clk);
        // R1 R2 R9 reads over every bank
        for (int b = 0; b < 4; b++) do_txn({b[1:0], 24'h12_3400 + 24'(b)}, 0, 0, 0, 0, 32'h0, 0, 1);
        // R8 writes long and short
        do_txn({2'd1, 24'hABCDEF}, 1, 0, 0, 0, 32'hDEAD_BEEF, 0, 1);
        do_txn({2'd2, 24'h000010}, 1, 0, 0, 1, 32'hCAFE_1234, 0, 1);
        do_txn({2'd3, 24'h00F0F0}, 0, 0, 0, 1, 32'h0, 0, 1);
        // R6 wait states
        for (int n = 1; n <= 3; n++) do_txn({2'(n), 24'h0A0000 + 24'(n)}, 0, 0, 0, 0, 32'h0, n, 1);
        do_txn({2'd0, 24'h55AA55}, 1, 0, 0, 0, 32'h1357_9BDF, 2, 1);
        // R4 R5 conditional accesses
        do_txn({2'd3, 24'h777777}, 1, 1, 0, 0, 32'hFFFF_0000, 2, 1);
        do_txn({2'd2, 24'h111111}, 1, 1, 1, 0, 32'h2468_ACE0, 1, 1);
        do_txn({2'd1, 24'h222222}, 0, 1, 0, 0, 32'h0, 0, 1);
        // R10 suspend in the middle of a waited read
        fork
            do_txn({2'd2, 24'h3C3C3C}, 0, 0, 0, 0, 32'h0, 3, 0);
            begin
                @(negedge clk);
                while (bus_rd_n) @(negedge clk);
                bus_susp = 1;
                @(negedge clk);
                chk(!bus_oe && bus_ms_n == 4'hF && bus_rd_n, "R10 floated and parked",
                    {26'd0, bus_oe, bus_ms_n, bus_rd_n}, 32'h1F);
                repeat (3) begin
                    @(negedge clk);
                    chk(!rsp_done && !bus_oe, "R10 no done while suspended", {30'd0, rsp_done, bus_oe}, 32'd0);
                end
                bus_susp = 0;
                @(negedge clk);
                chk(bus_oe && bus_ms_n == 4'b1011, "R10 restart from address phase",
                    {27'd0, bus_oe, bus_ms_n}, 32'h1B);
            end
        join
        // R10 suspend before a request arrives
        bus_susp = 1;
        @(negedge clk);
        chk(!bus_oe, "R10 float while idle", {31'd0, bus_oe}, 32'd0);
        fork
            do_txn({2'd0, 24'h0BEEF0}, 1, 0, 0, 0, 32'h0BAD_F00D, 0, 0);
            begin
                repeat (5) begin
                    @(negedge clk);
                    chk(!rsp_done && bus_wr_n, "R10 stalled access", {30'd0, rsp_done, bus_wr_n}, 32'd1);
                end
                bus_susp = 0;
            end
        join
        chk(sb.size() == 0, "R2 all accesses completed", sb.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R2 actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule